// File: doc/BRIEF.md
# Nested Interrupt In-Service Level Tracker

This block keeps a record of which fast-interrupt priority levels are currently being serviced when nested handling is in use. There are eight levels. Level 0 is the most urgent and level 7 the least. When nesting is switched on and the handler reads the interrupt vector, the block marks the level of the interrupt being entered as in service. From that record it drives a blocking mask. A pending request is held off when its own level, or any more urgent level, is still in service.

Software ends a handler by writing the status register. The value written does not matter. Each write retires exactly one level, and it is always the most urgent in-service level, so levels leave service in the reverse order of their nesting, like a stack. A small controller follows two named states. EMPTY means no level is in service and NESTED means one or more are. It moves between them through the transitions PUSH (EMPTY to NESTED, a level is entered), RETIRE_LAST (NESTED to EMPTY, the write clears the only level left), and STAY (every other case, including a write and a vector read in the same cycle). The arbiter that picks the winning request and the vector generator are outside this block.

Top module: `nest_level_tracker`

## Requirements
- R1: After reset, `status` is 0x00 and `block_mask` is 0x00.
- R2: When `nest_en` is 1 and `vec_rd` is pulsed, bit `vec_prio` of `status` is 1 from the next clock edge. Bit N stands for level N, and level 0 is the most urgent.
- R3: When `nest_en` is 0, a `vec_rd` pulse sets no bit of `status`.
- R4: Each `stat_wr` pulse clears only the lowest-numbered set bit of `status`, whatever data is written. From 0x09, one write gives 0x08 and a second write gives 0x00.
- R5: A `stat_wr` pulse while `status` is 0x00 leaves `status` at 0x00.
- R6: When `stat_wr` and an enabled `vec_rd` occur in the same cycle, the clear is applied first and the new bit is set afterwards. From 0x04, reading level 2 gives 0x04 and reading level 5 gives 0x20.
- R7: `block_mask` bit N is 1 exactly when any `status` bit from 0 to N is 1. This is combinational from `status`.
- R8: Without a `vec_rd` or `stat_wr` pulse, `status` holds its value.
- R9: A vector read for a level that is already in service leaves `status` unchanged when no write occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nest_en | input | 1 | Nesting enable |
| vec_rd | input | 1 | Vector-read strobe, one cycle |
| vec_prio | input | 3 | Priority level of the interrupt being entered |
| stat_wr | input | 1 | Status write strobe (end of handler) |
| status | output | 8 | In-service level bits |
| block_mask | output | 8 | Levels currently blocked |

## Verification
The bench builds the block with its default of eight levels and a 3-bit priority input, so every level index can be driven and both the most urgent and the least urgent level can be hit. Directed sequences cover the 0x09 example, writes to an empty register, simultaneous retire-and-enter at the same level and at a different level, and vector reads with nesting disabled. A long stretch of random strobes then walks the register through deep nesting and full unwinding. On every cycle the result is compared against a behavioural model.

// File: rtl/nest_pkg.sv
package nest_pkg;
    localparam int unsigned DEF_LEVELS = 8;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_NESTED = 1'b1
    } nest_state_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2,
        ACT_SWAP = 2'd3
    } nest_act_e;
endpackage

// File: rtl/nest_block_mask.sv
module nest_block_mask #(
    parameter int unsigned LEVELS = 8
) (
    input  logic [LEVELS-1:0] status,
    output logic [LEVELS-1:0] mask
);
    // Prefix OR from the most urgent level (bit 0) upward.
    assign mask[0] = status[0];
    for (genvar i = 1; i < LEVELS; i++) begin : g_prefix
        assign mask[i] = mask[i-1] | status[i];
    end

    // R7: the mask never has a gap above its lowest set bit.
    always_comb begin
        for (int k = 1; k < LEVELS; k++) begin
            p_mask_monotone_r7: assert (!mask[k-1] || mask[k]);
        end
    end
endmodule

// File: rtl/nest_lowest_pick.sv
module nest_lowest_pick #(
    parameter int unsigned LEVELS = 8
) (
    input  logic [LEVELS-1:0] status,
    input  logic [LEVELS-1:0] mask,
    output logic [LEVELS-1:0] pick
);
    // A bit is picked when it is set and no more urgent bit is set.
    assign pick[0] = status[0];
    for (genvar i = 1; i < LEVELS; i++) begin : g_pick
        assign pick[i] = status[i] & ~mask[i-1];
    end

    // R4: the selected bit is unique and present whenever status is non-zero.
    always_comb begin
        p_pick_onehot_r4: assert ($onehot0(pick));
        p_pick_present_r4: assert ((status == '0) || (pick != '0));
    end
endmodule

// File: rtl/nest_stack_ctrl.sv
module nest_stack_ctrl
    import nest_pkg::*;
#(
    parameter int unsigned LEVELS = 8,
    localparam int unsigned PRIO_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nest_en,
    input  logic              vec_rd,
    input  logic [PRIO_W-1:0] vec_prio,
    input  logic              stat_wr,
    input  logic [LEVELS-1:0] retire_pick,
    output logic [LEVELS-1:0] status_q
);
    nest_state_e       state_q, state_d;
    nest_act_e         act;
    logic [LEVELS-1:0] enter_bit;
    logic [LEVELS-1:0] status_d;
    logic              do_enter;
    logic              do_retire;

    // One-hot decode of the level being entered.
    for (genvar i = 0; i < LEVELS; i++) begin : g_dec
        assign enter_bit[i] = (vec_prio == PRIO_W'(i));
    end

    assign do_enter  = nest_en & vec_rd;
    assign do_retire = stat_wr & (status_q != '0);

    always_comb begin
        unique case ({do_enter, do_retire})
            2'b10:   act = ACT_PUSH;
            2'b01:   act = ACT_POP;
            2'b11:   act = ACT_SWAP;
            default: act = ACT_NONE;
        endcase
    end

    // Next-state and next-status process: clear first, then set.
    always_comb begin
        status_d = status_q;
        state_d  = state_q;
        unique case (act)
            ACT_PUSH: status_d = status_q | enter_bit;
            ACT_POP:  status_d = status_q & ~retire_pick;
            ACT_SWAP: status_d = (status_q & ~retire_pick) | enter_bit;
            default:  status_d = status_q;
        endcase
        unique case (state_q)
            ST_EMPTY: begin
                // PUSH
                if (act == ACT_PUSH) state_d = ST_NESTED;
            end
            ST_NESTED: begin
                // RETIRE_LAST
                if (status_d == '0) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_EMPTY;
            status_q <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    p_state_tracks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) == (status_q == '0));
    p_set_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_en && vec_rd) |=> status_q[$past(vec_prio)]);
    p_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nest_en && vec_rd) |=> ((status_q & ~$past(status_q)) == '0));
    p_clear_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !(nest_en && vec_rd) && status_q != '0) |=>
        ($countones(status_q) + 1 == $countones($past(status_q))));
    p_empty_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !vec_rd && status_q == '0) |=> (status_q == '0));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_rd && !stat_wr) |=> $stable(status_q));
endmodule

// File: rtl/nest_level_tracker.sv
module nest_level_tracker
    import nest_pkg::*;
#(
    parameter int unsigned LEVELS = DEF_LEVELS,
    localparam int unsigned PRIO_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nest_en,
    input  logic              vec_rd,
    input  logic [PRIO_W-1:0] vec_prio,
    input  logic              stat_wr,
    output logic [LEVELS-1:0] status,
    output logic [LEVELS-1:0] block_mask
);
    logic [LEVELS-1:0] status_q;
    logic [LEVELS-1:0] mask_w;
    logic [LEVELS-1:0] pick_w;

    nest_stack_ctrl #(.LEVELS(LEVELS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .nest_en     (nest_en),
        .vec_rd      (vec_rd),
        .vec_prio    (vec_prio),
        .stat_wr     (stat_wr),
        .retire_pick (pick_w),
        .status_q    (status_q)
    );

    nest_block_mask #(.LEVELS(LEVELS)) u_mask (
        .status (status_q),
        .mask   (mask_w)
    );

    nest_lowest_pick #(.LEVELS(LEVELS)) u_pick (
        .status (status_q),
        .mask   (mask_w),
        .pick   (pick_w)
    );

    assign status     = status_q;
    assign block_mask = mask_w;

    // R7: the most urgent in-service level is always blocked.
    p_lowest_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((block_mask & status) == status));
    // R9: re-entering a level already in service changes nothing.
    p_reenter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_en && vec_rd && !stat_wr && status[vec_prio]) |=> $stable(status));
endmodule

// File: tb/tb_nest_level_tracker.sv
module tb_nest_level_tracker;
    localparam int LEVELS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nest_en = 1'b0;
    logic       vec_rd = 1'b0;
    logic [2:0] vec_prio = 3'd0;
    logic       stat_wr = 1'b0;
    logic [7:0] status;
    logic [7:0] block_mask;

    int checks = 0;
    int errors = 0;
    int model_stat = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nest_level_tracker #(.LEVELS(LEVELS)) dut (
        .clk(clk), .rst_n(rst_n), .nest_en(nest_en), .vec_rd(vec_rd),
        .vec_prio(vec_prio), .stat_wr(stat_wr),
        .status(status), .block_mask(block_mask)
    );

    function automatic int exp_mask(input int s);
        int m = 0;
        bit seen = 0;
        for (int i = 0; i < LEVELS; i++) begin
            if ((s >> i) & 1) seen = 1;
            if (seen) m = m | (1 << i);
        end
        return m;
    endfunction

    function automatic int retire_one(input int s);
        for (int i = 0; i < LEVELS; i++) begin
            if ((s >> i) & 1) return s & ~(1 << i);
        end
        return s;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (int'(status) != model_stat) begin
            errors++;
            $display("FAIL %s status actual=%02h expected=%02h", tag, status, model_stat[7:0]);
        end
        checks++;
        if (int'(block_mask) != exp_mask(model_stat)) begin
            errors++;
            $display("FAIL R7 block_mask actual=%02h expected=%02h", block_mask,
                     exp_mask(model_stat));
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, update the model at the
    // rising edge, compare at the next falling edge.
    task automatic step(input bit en, input bit rd, input int prio, input bit wr,
                        input string tag);
        nest_en = en; vec_rd = rd; vec_prio = prio[2:0]; stat_wr = wr;
        @(posedge clk);
        if (wr) model_stat = retire_one(model_stat);
        if (en && rd) model_stat = model_stat | (1 << prio);
        @(negedge clk);
        nest_en = 1'b0; vec_rd = 1'b0; stat_wr = 1'b0;
        check(tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_stat = 0;
        check("R1");
        // R2: build 0x09
        step(1, 1, 3, 0, "R2");
        step(1, 1, 0, 0, "R2");
        // R4: 0x09 -> 0x08 -> 0x00
        step(0, 0, 0, 1, "R4");
        step(0, 0, 0, 1, "R4");
        // R5: write on empty
        step(0, 0, 0, 1, "R5");
        // R3: vector read with nesting off
        step(0, 1, 6, 0, "R3");
        step(0, 1, 0, 0, "R3");
        // R8: idle cycles hold
        step(1, 0, 4, 0, "R8");
        // R6: from 0x04, same-level swap, then different level
        step(1, 1, 2, 0, "R2");
        step(1, 1, 2, 1, "R6");
        step(1, 1, 5, 1, "R6");
        // R9: re-enter level 5
        step(1, 1, 5, 0, "R9");
        // Edge levels 7 and 0
        step(1, 1, 7, 0, "R2");
        step(1, 1, 0, 0, "R2");
        step(0, 0, 0, 1, "R4");
        step(0, 0, 0, 1, "R4");
        step(0, 0, 0, 1, "R4");
        step(0, 0, 0, 1, "R5");
        // Full stack then unwind
        for (int l = LEVELS - 1; l >= 0; l--) step(1, 1, l, 0, "R2");
        for (int l = 0; l < LEVELS + 1; l++) step(0, 0, 0, 1, "R4");
        // Random walk
        for (int n = 0; n < 3000; n++) begin
            bit en = ($urandom % 4) != 0;
            bit rd = ($urandom % 2) == 1;
            bit wr = ($urandom % 3) == 0;
            int p = int'($urandom % LEVELS);
            step(en, rd, p, wr, (rd && wr) ? "R6" : (wr ? "R4" : (rd ? "R2" : "R8")));
        end
        // Reset mid-use
        step(1, 1, 6, 0, "R2");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_stat = 0;
        check("R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule